// File: doc/BRIEF.md
# Debug Bus Access Comparator

The block is a breakpoint comparator for on-chip debug. It watches a processor's data-access bus and its stream of executed program-counter values. When the access selected by software occurs, it raises a single-cycle `match_o` pulse. A debug trigger sequencer can count or act on that pulse.

Software sets the comparator up through a byte-wide register port. Four registers are held:

- a control byte;
- a compare address;
- a compare data value;
- a per-bit data mask.

In data mode the block matches on the following conditions:

- address equality;
- masked data equality;
- optionally the access direction.

In instruction mode it matches on the executed program counter alone. A 16-bit secondary bus master can share the data-access port. Its accesses are compared only on the low 16 data bits.

Register writes are accepted only while the debugger is disarmed and the external trigger is inactive. Reads are always allowed, so the set-up can be inspected while a breakpoint is live.

Top module: `bus_access_comparator`

## Requirements
- R1: After reset, every register byte reads 0x00 and `match_o` is low.
- R2: Register byte address 0 is the control byte. Addresses 1 to 4 hold the compare address, 5 to 8 the compare data and 9 to 12 the data mask. Within each group the first byte is bits 31:24, the second 23:16, the third 15:8 and the fourth 7:0.
- R3: Every register byte can be read back at any time on `cfg_rdata_o`. Control bits 7, 6, 4 and 1 always read as zero.
- R4: A write is ignored while `dbg_armed_i` or `trig_active_i` is high. The targeted byte keeps its old value.
- R5: Control bit 0 is the enable. While it is 0, `match_o` never rises.
- R6: A data mask bit of 1 makes the matching data bit take part in the compare. A mask bit of 0 makes that bit a don't-care.
- R7: When `dacc_narrow_i` is high, only data bits 15:0 are compared, whatever the mask holds for bits 31:16.
- R8: Control bit 5 set to 1 selects instruction mode. In this mode a match needs `pc_valid_i` and `pc_i` equal to the compare address. Data, mask, direction and the data-access strobe have no effect.
- R9: In data mode, control bit 2 set to 1 adds the direction to the match condition. Control bit 3 then selects the direction: 1 matches reads (`dacc_rd_i`=1) and 0 matches writes. While bit 2 is 0, bit 3 has no effect.
- R10: In data mode a match needs `dacc_valid_i` and all enabled conditions in the same cycle. `match_o` is high in the cycle after that strobe and low again after a cycle with no qualifying strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register byte write strobe |
| cfg_addr_i | input | REG_AW | Register byte address, used for both writes and reads |
| cfg_wdata_i | input | 8 | Register write byte |
| cfg_rdata_o | output | 8 | Register read byte for `cfg_addr_i` |
| dbg_armed_i | input | 1 | Debugger armed; blocks writes |
| trig_active_i | input | 1 | External trigger active; blocks writes |
| dacc_addr_i | input | AW | Data access address |
| dacc_data_i | input | DW | Data access value |
| dacc_rd_i | input | 1 | Access direction, 1 = read |
| dacc_narrow_i | input | 1 | Access comes from the 16-bit secondary master |
| dacc_valid_i | input | 1 | Data access valid strobe |
| pc_i | input | AW | Executed program-counter value |
| pc_valid_i | input | 1 | Program-counter valid strobe |
| match_o | output | 1 | Match pulse, one cycle after the qualifying strobe |

## Verification
A corrupted control or compare register shows up directly on `cfg_rdata_o` as soon as its byte address is read. A wrong compare value also shows up on the next qualifying access as a missing or spurious `match_o` pulse one cycle after the strobe.

A mistake in qualification is exposed by pairs of accesses that differ in a single field. Such mistakes include:

- the mask polarity;
- the narrow-lane gating;
- the instruction-mode precedence;
- the direction precedence.

In each pair, one access must produce a pulse and the other must not. A register that held the match flag for too long is seen in the cycle after the strobe drops.

// File: rtl/bus_access_comparator_pkg.sv
package bus_access_comparator_pkg;
  // control byte bit positions
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_RWE_BIT  = 2;
  localparam int CTL_RWV_BIT  = 3;
  localparam int CTL_INST_BIT = 5;

  typedef struct packed {
    logic inst;
    logic rwv;
    logic rwe;
    logic en;
  } cmp_ctrl_t;
endpackage

// File: rtl/cmp_cfg_regs.sv
module cmp_cfg_regs
  import bus_access_comparator_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int REG_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              lock_i,
  output logic [7:0]        rdata_o,
  output cmp_ctrl_t         ctrl_o,
  output logic [AW-1:0]     cmp_addr_o,
  output logic [DW-1:0]     cmp_data_o,
  output logic [DW-1:0]     cmp_mask_o
);
  localparam int NB_A  = AW / 8;
  localparam int NB_D  = DW / 8;
  localparam int OFS_A = 1;
  localparam int OFS_D = OFS_A + NB_A;
  localparam int OFS_M = OFS_D + NB_D;

  cmp_ctrl_t     ctrl_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] mask_q;
  logic          wr_ok;
  logic          unused_wbits;

  assign wr_ok        = we_i && !lock_i;
  assign unused_wbits = ^{wdata_i[7:6], wdata_i[4], wdata_i[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else if (wr_ok) begin
      if (addr_i == '0) begin
        ctrl_q.inst <= wdata_i[CTL_INST_BIT];
        ctrl_q.rwv  <= wdata_i[CTL_RWV_BIT];
        ctrl_q.rwe  <= wdata_i[CTL_RWE_BIT];
        ctrl_q.en   <= wdata_i[CTL_EN_BIT];
      end
      // first byte of each group is the most significant lane
      for (int k = 0; k < NB_A; k++)
        if (addr_i == REG_AW'(OFS_A + k)) addr_q[(NB_A-1-k)*8 +: 8] <= wdata_i;
      for (int k = 0; k < NB_D; k++) begin
        if (addr_i == REG_AW'(OFS_D + k)) data_q[(NB_D-1-k)*8 +: 8] <= wdata_i;
        if (addr_i == REG_AW'(OFS_M + k)) mask_q[(NB_D-1-k)*8 +: 8] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      rdata_o[CTL_INST_BIT] = ctrl_q.inst;
      rdata_o[CTL_RWV_BIT]  = ctrl_q.rwv;
      rdata_o[CTL_RWE_BIT]  = ctrl_q.rwe;
      rdata_o[CTL_EN_BIT]   = ctrl_q.en;
    end
    for (int k = 0; k < NB_A; k++)
      if (addr_i == REG_AW'(OFS_A + k)) rdata_o = addr_q[(NB_A-1-k)*8 +: 8];
    for (int k = 0; k < NB_D; k++) begin
      if (addr_i == REG_AW'(OFS_D + k)) rdata_o = data_q[(NB_D-1-k)*8 +: 8];
      if (addr_i == REG_AW'(OFS_M + k)) rdata_o = mask_q[(NB_D-1-k)*8 +: 8];
    end
  end

  assign ctrl_o     = ctrl_q;
  assign cmp_addr_o = addr_q;
  assign cmp_data_o = data_q;
  assign cmp_mask_o = mask_q;

  // R4: a locked write leaves all configuration untouched
  assert_locked_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lock_i) |=> ($stable(ctrl_q) && $stable(addr_q) &&
                          $stable(data_q) && $stable(mask_q)));
endmodule

// File: rtl/cmp_match_core.sv
module cmp_match_core
  import bus_access_comparator_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NW = 16
) (
  input  cmp_ctrl_t     ctrl_i,
  input  logic [AW-1:0] cmp_addr_i,
  input  logic [DW-1:0] cmp_data_i,
  input  logic [DW-1:0] cmp_mask_i,
  input  logic [AW-1:0] dacc_addr_i,
  input  logic [DW-1:0] dacc_data_i,
  input  logic          dacc_rd_i,
  input  logic          dacc_narrow_i,
  input  logic          dacc_valid_i,
  input  logic [AW-1:0] pc_i,
  input  logic          pc_valid_i,
  output logic          hit_o
);
  logic [DW-1:0] narrow_keep;
  logic [DW-1:0] eff_mask;
  logic          data_ok;
  logic          dir_ok;
  logic          data_hit;
  logic          pc_hit;

  generate
    if (DW > NW) begin : g_narrow_gate
      assign narrow_keep = {{(DW-NW){1'b0}}, {NW{1'b1}}};
    end else begin : g_narrow_full
      assign narrow_keep = '1;
    end
  endgenerate

  assign eff_mask = dacc_narrow_i ? (cmp_mask_i & narrow_keep) : cmp_mask_i;
  assign data_ok  = ((dacc_data_i ^ cmp_data_i) & eff_mask) == '0;
  // direction enable gates the direction value
  assign dir_ok   = !ctrl_i.rwe || (dacc_rd_i == ctrl_i.rwv);
  assign data_hit = dacc_valid_i && (dacc_addr_i == cmp_addr_i) && data_ok && dir_ok;
  assign pc_hit   = pc_valid_i && (pc_i == cmp_addr_i);
  // instruction mode overrides all data-side qualifiers
  assign hit_o    = ctrl_i.en && (ctrl_i.inst ? pc_hit : data_hit);
endmodule

// File: rtl/bus_access_comparator.sv
module bus_access_comparator
  import bus_access_comparator_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int NW     = 16,
  parameter int REG_AW = $clog2(1 + AW/8 + 2*(DW/8))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [REG_AW-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              dbg_armed_i,
  input  logic              trig_active_i,
  input  logic [AW-1:0]     dacc_addr_i,
  input  logic [DW-1:0]     dacc_data_i,
  input  logic              dacc_rd_i,
  input  logic              dacc_narrow_i,
  input  logic              dacc_valid_i,
  input  logic [AW-1:0]     pc_i,
  input  logic              pc_valid_i,
  output logic              match_o
);
  cmp_ctrl_t     ctrl;
  logic [AW-1:0] cmp_addr;
  logic [DW-1:0] cmp_data;
  logic [DW-1:0] cmp_mask;
  logic          hit;

  cmp_cfg_regs #(.AW(AW), .DW(DW), .REG_AW(REG_AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .lock_i     (dbg_armed_i || trig_active_i),
    .rdata_o    (cfg_rdata_o),
    .ctrl_o     (ctrl),
    .cmp_addr_o (cmp_addr),
    .cmp_data_o (cmp_data),
    .cmp_mask_o (cmp_mask)
  );

  cmp_match_core #(.AW(AW), .DW(DW), .NW(NW)) u_core (
    .ctrl_i        (ctrl),
    .cmp_addr_i    (cmp_addr),
    .cmp_data_i    (cmp_data),
    .cmp_mask_i    (cmp_mask),
    .dacc_addr_i   (dacc_addr_i),
    .dacc_data_i   (dacc_data_i),
    .dacc_rd_i     (dacc_rd_i),
    .dacc_narrow_i (dacc_narrow_i),
    .dacc_valid_i  (dacc_valid_i),
    .pc_i          (pc_i),
    .pc_valid_i    (pc_valid_i),
    .hit_o         (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_o <= 1'b0;
    else         match_o <= hit;
  end

  assert_off_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |=> !match_o);

  assert_needs_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(ctrl.inst ? pc_valid_i : dacc_valid_i));

  assert_inst_pc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && $past(ctrl.inst)) |-> $past(pc_i == cmp_addr));

  assert_dir_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && $past(!ctrl.inst && ctrl.rwe)) |-> $past(dacc_rd_i == ctrl.rwv));
endmodule

// File: tb/bus_access_comparator_tb_top.sv
module bus_access_comparator_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic        dbg_armed_i = 1'b0;
  logic        trig_active_i = 1'b0;
  logic [31:0] dacc_addr_i = '0;
  logic [31:0] dacc_data_i = '0;
  logic        dacc_rd_i = 1'b0;
  logic        dacc_narrow_i = 1'b0;
  logic        dacc_valid_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic        pc_valid_i = 1'b0;
  logic        match_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  bus_access_comparator dut_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .dbg_armed_i, .trig_active_i, .dacc_addr_i, .dacc_data_i, .dacc_rd_i,
    .dacc_narrow_i, .dacc_valid_i, .pc_i, .pc_valid_i, .match_o
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic wr32(input logic [3:0] base, input logic [31:0] v);
    for (int k = 0; k < 4; k++) wr_byte(base + 4'(k), v[31-8*k -: 8]);
  endtask

  task automatic rd_byte(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1 d = cfg_rdata_o;
  endtask

  // one strobe cycle; returns match_o one cycle later
  task automatic bus(input logic [31:0] a, input logic [31:0] d, input logic rd,
                     input logic nar, input logic dv, input logic [31:0] pc,
                     input logic pv, output logic m);
    @(negedge clk_i);
    dacc_addr_i = a; dacc_data_i = d; dacc_rd_i = rd; dacc_narrow_i = nar;
    dacc_valid_i = dv; pc_i = pc; pc_valid_i = pv;
    @(posedge clk_i); #1 m = match_o;
    @(negedge clk_i);
    dacc_valid_i = 1'b0; pc_valid_i = 1'b0;
  endtask

  task automatic dacc(input logic [31:0] a, input logic [31:0] d, input logic rd,
                      input logic nar, output logic m);
    bus(a, d, rd, nar, 1'b1, 32'h0, 1'b0, m);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check(match_o === 1'b0, "R1 match after reset", 32'(match_o), 0);
    for (int a = 0; a < 13; a++) begin
      rd_byte(4'(a), d);
      check(d === 8'h00, "R1 reg reset value", 32'(d), 0);
    end
  endtask

  task automatic t_lanes;
    logic [7:0] d;
    logic m;
    wr32(4'd1, 32'h11223344);
    rd_byte(4'd1, d); check(d === 8'h11, "R2 addr lane0", 32'(d), 32'h11);
    rd_byte(4'd4, d); check(d === 8'h44, "R2 addr lane3", 32'(d), 32'h44);
    wr32(4'd5, 32'hAB000000);
    wr32(4'd9, 32'hFF000000);
    wr_byte(4'd0, 8'h01);
    dacc(32'h11223344, 32'hAB123456, 1'b0, 1'b0, m);
    check(m === 1'b1, "R2 mask lane0 is bits 31:24 (match)", 32'(m), 1);
    dacc(32'h11223344, 32'hAC000000, 1'b0, 1'b0, m);
    check(m === 1'b0, "R2 mask lane0 is bits 31:24 (miss)", 32'(m), 0);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    wr_byte(4'd0, 8'hFF);
    rd_byte(4'd0, d); check(d === 8'h2D, "R3 reserved ctrl bits read zero", 32'(d), 32'h2D);
    wr_byte(4'd0, 8'h00);
    rd_byte(4'd0, d); check(d === 8'h00, "R3 ctrl readback cleared", 32'(d), 0);
  endtask

  task automatic t_lock;
    logic [7:0] d;
    logic m;
    wr_byte(4'd0, 8'h00);
    dbg_armed_i = 1'b1;
    wr_byte(4'd0, 8'h01);
    wr_byte(4'd1, 8'h99);
    rd_byte(4'd0, d); check(d === 8'h00, "R4 armed blocks ctrl write", 32'(d), 0);
    rd_byte(4'd1, d); check(d === 8'h11, "R4 armed blocks addr write", 32'(d), 32'h11);
    dacc(32'h11223344, 32'hAB000000, 1'b0, 1'b0, m);
    check(m === 1'b0, "R4 blocked enable gives no match", 32'(m), 0);
    dbg_armed_i = 1'b0; trig_active_i = 1'b1;
    wr_byte(4'd9, 8'h00);
    rd_byte(4'd9, d); check(d === 8'hFF, "R4 trigger blocks mask write", 32'(d), 32'hFF);
    trig_active_i = 1'b0;
    wr_byte(4'd9, 8'h0F);
    rd_byte(4'd9, d); check(d === 8'h0F, "R4 write accepted when unlocked", 32'(d), 32'h0F);
    wr_byte(4'd9, 8'hFF);
  endtask

  task automatic t_enable;
    logic m;
    wr_byte(4'd0, 8'h00);
    dacc(32'h11223344, 32'hAB000000, 1'b0, 1'b0, m);
    check(m === 1'b0, "R5 disabled no match", 32'(m), 0);
    wr_byte(4'd0, 8'h01);
    dacc(32'h11223344, 32'hAB000000, 1'b0, 1'b0, m);
    check(m === 1'b1, "R5 enabled match", 32'(m), 1);
  endtask

  task automatic t_mask;
    logic m;
    wr32(4'd1, 32'h00002000);
    wr32(4'd5, 32'h50607080);
    wr32(4'd9, 32'hF0F0F0F0);
    wr_byte(4'd0, 8'h01);
    dacc(32'h00002000, 32'h5A6B7C8D, 1'b1, 1'b0, m);
    check(m === 1'b1, "R6 masked-off bits ignored", 32'(m), 1);
    dacc(32'h00002000, 32'h40607080, 1'b1, 1'b0, m);
    check(m === 1'b0, "R6 masked-in bit differs", 32'(m), 0);
    dacc(32'h00002004, 32'h50607080, 1'b1, 1'b0, m);
    check(m === 1'b0, "R6 address differs", 32'(m), 0);
  endtask

  task automatic t_narrow;
    logic m;
    wr32(4'd5, 32'h12345678);
    wr32(4'd9, 32'hFFFFFFFF);
    dacc(32'h00002000, 32'hFFFF5678, 1'b0, 1'b1, m);
    check(m === 1'b1, "R7 narrow ignores upper half", 32'(m), 1);
    dacc(32'h00002000, 32'hFFFF5678, 1'b0, 1'b0, m);
    check(m === 1'b0, "R7 wide compares upper half", 32'(m), 0);
    dacc(32'h00002000, 32'h12345679, 1'b0, 1'b1, m);
    check(m === 1'b0, "R7 narrow compares low half", 32'(m), 0);
  endtask

  task automatic t_inst;
    logic m;
    wr32(4'd1, 32'h00001000);
    wr_byte(4'd0, 8'h2D);
    bus(32'h0, 32'hDEADBEEF, 1'b0, 1'b0, 1'b0, 32'h00001000, 1'b1, m);
    check(m === 1'b1, "R8 pc match ignores data and direction", 32'(m), 1);
    bus(32'h00001000, 32'h12345678, 1'b1, 1'b0, 1'b1, 32'h00001000, 1'b0, m);
    check(m === 1'b0, "R8 data access ignored in inst mode", 32'(m), 0);
    bus(32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h00001004, 1'b1, m);
    check(m === 1'b0, "R8 pc differs", 32'(m), 0);
  endtask

  task automatic t_dir;
    logic m;
    wr32(4'd5, 32'h12345678);
    wr_byte(4'd0, 8'h05);
    dacc(32'h00001000, 32'h12345678, 1'b0, 1'b0, m);
    check(m === 1'b1, "R9 write matched", 32'(m), 1);
    dacc(32'h00001000, 32'h12345678, 1'b1, 1'b0, m);
    check(m === 1'b0, "R9 read rejected", 32'(m), 0);
    wr_byte(4'd0, 8'h0D);
    dacc(32'h00001000, 32'h12345678, 1'b1, 1'b0, m);
    check(m === 1'b1, "R9 read matched", 32'(m), 1);
    dacc(32'h00001000, 32'h12345678, 1'b0, 1'b0, m);
    check(m === 1'b0, "R9 write rejected", 32'(m), 0);
    wr_byte(4'd0, 8'h09);
    dacc(32'h00001000, 32'h12345678, 1'b0, 1'b0, m);
    check(m === 1'b1, "R9 direction off, write", 32'(m), 1);
    dacc(32'h00001000, 32'h12345678, 1'b1, 1'b0, m);
    check(m === 1'b1, "R9 direction off, read", 32'(m), 1);
  endtask

  task automatic t_timing;
    logic m;
    wr_byte(4'd0, 8'h01);
    bus(32'h00001000, 32'h12345678, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, m);
    check(m === 1'b0, "R10 no strobe no match", 32'(m), 0);
    @(negedge clk_i);
    dacc_addr_i = 32'h00001000; dacc_data_i = 32'h12345678; dacc_valid_i = 1'b1;
    #1 check(match_o === 1'b0, "R10 low before edge", 32'(match_o), 0);
    @(posedge clk_i); #1
    check(match_o === 1'b1, "R10 high one cycle after strobe", 32'(match_o), 1);
    @(negedge clk_i); dacc_valid_i = 1'b0;
    @(posedge clk_i); #1
    check(match_o === 1'b0, "R10 single cycle pulse", 32'(match_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_lanes();
    t_readback();
    t_lock();
    t_enable();
    t_mask();
    t_narrow();
    t_inst();
    t_dir();
    t_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule